// File: doc/BRIEF.md
# Multi-queue thread dispatch scheduler

This block hands shader threads to a small pool of shader clusters. Three producers (vertex, geometry and pixel) each feed their own thread queue through a valid/ready port carrying a thread ID. Each cluster has its own round-robin arbiter that picks which queue supplies its next thread. A cluster arbiter rotates the starting cluster after each dispatch, so successive threads are spread across the clusters. At most one thread is dispatched per cycle.

A cluster that finishes a thread raises its retire bit. A cluster whose thread stalls on a memory fetch raises the suspend input. The block then frees that cluster and puts the thread back at the tail of its own queue, marked as waiting. A waiting thread is not dispatched again until a data-return event with its ID arrives. Until then its queue is skipped while its head is waiting, so stalled work never occupies a cluster. A separate round-robin arbiter, independent of the dispatch path, grants one fetch request per cycle.

Top module: `thread_dispatch_sched`

## Requirements
- R1: `in_ready[q]` is low exactly when the entries held in queue q plus the threads of type q running on clusters equal the queue depth (8). A valid thread is accepted only in a cycle when `in_ready` for its lane is high. Lane 0 is vertex (type code 0), lane 1 is geometry (code 1) and lane 2 is pixel (code 2).
- R2: Each cluster keeps its own queue pointer and grants the first queue, in the order 0, 1, 2 cyclically from that pointer, whose head is ready. After a grant the pointer moves to the queue after the one granted. Each pointer starts at queue 0.
- R3: A dispatch goes to the first free cluster at or after the cluster following the one last dispatched to. The first dispatch after reset goes to cluster 0. At most one `iss_valid` bit is high per cycle. A dispatch is seen at the ports two clock edges after the thread is accepted.
- R4: A retire pulse on a busy cluster frees it, and its thread stops counting toward the R1 limit. When retire and suspend hit the same cluster in one cycle, the retire wins.
- R5: A suspend on a busy cluster frees that cluster and appends its thread, marked waiting, to the tail of the queue of the thread's type.
- R6: A waiting thread is never dispatched. While a queue's head is waiting, that queue is skipped and other queues are still served. A data return carrying the thread's ID makes it eligible for any free cluster.
- R7: In a cycle with an accepted suspension into queue q, `in_ready[q]` is low, so a requeued thread always has room and is never dropped.
- R8: A data return whose ID matches no waiting thread changes nothing.
- R9: The fetch arbiter grants at most one requester per cycle. It searches round-robin from the requester after the previous grant, and its pointer starts at requester 0.
- R10: Every accepted thread is dispatched once, plus once more for each suspension, and is retired exactly once.
- R11: After reset, no `iss_valid` or `fetch_gnt` bit is high and all three `in_ready` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 3 | Producer valid, one bit per lane (0 vertex, 1 geometry, 2 pixel) |
| in_tid | input | 18 | Producer thread IDs, lane q in bits [6q+5:6q] |
| in_ready | output | 3 | Lane may accept a thread |
| iss_valid | output | 4 | One-cycle dispatch pulse per cluster |
| iss_tid | output | 24 | Thread ID on each cluster, cluster c in bits [6c+5:6c] |
| iss_type | output | 8 | Type code of the thread on each cluster, 2 bits per cluster |
| done_valid | input | 4 | Retire pulse per cluster |
| susp_valid | input | 1 | A cluster's thread stalled on a fetch |
| susp_cl | input | 2 | Index of the stalling cluster |
| ret_valid | input | 1 | Data-return event |
| ret_tid | input | 6 | Thread ID of the data return |
| fetch_req | input | 4 | Fetch request per cluster |
| fetch_gnt | output | 4 | One-hot fetch grant |

## Verification
Two collisions are driven into the same cycle. In the first, a suspension into the vertex queue and a new vertex arrival come together. The bench judges it by `in_ready[0]` falling in that cycle while the other lanes stay high, and later by the scoreboard holding the requeued thread while the rejected one never appears. In the second, a retire frees a cluster and, in the same cycle, the vertex reservation is released. This is judged by `in_ready[0]` rising and the freed cluster receiving the next vertex thread two edges later. A data return for an unknown ID is sent while a waiting head sits at the front of a queue, and the bench checks that no dispatch follows.

// File: rtl/tds_pkg.sv
package tds_pkg;
   localparam int NUM_QUEUES = 3;
   localparam int TYPE_W     = 2;

   typedef enum logic [TYPE_W-1:0] {
      TT_VERT = 2'd0,
      TT_GEOM = 2'd1,
      TT_PIX  = 2'd2
   } thr_type_e;

   // index of the lowest set bit of a one-hot (or zero) vector
   function automatic int oh2idx(input logic [31:0] v);
      int r;
      r = 0;
      for (int i = 31; i >= 0; i--) if (v[i]) r = i;
      return r;
   endfunction
endpackage

// File: rtl/tds_rr_arb.sv
module tds_rr_arb #(
   parameter int N = 3,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] gnt
);
   if (N < 2 || N > 32) begin : g_bad_n
      $error("tds_rr_arb: N must lie in 2..32");
   end

   logic [IW-1:0] ptr;
   logic [IW-1:0] win;
   logic          hit;

   always_comb begin
      gnt = '0;
      win = '0;
      hit = 1'b0;
      for (int i = 0; i < N; i++) begin
         int idx;
         idx = int'(ptr) + i;
         if (idx >= N) idx = idx - N;
         if (!hit && req[idx]) begin
            hit      = 1'b1;
            gnt[idx] = 1'b1;
            win      = IW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) ptr <= '0;
      else if (adv && hit) ptr <= (int'(win) == N - 1) ? '0 : win + IW'(1);
   end

   // R9
   grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt) && ((gnt & ~req) == '0));
   // R2
   grant_live_chk: assert property (@(posedge clk) disable iff (rst)
      (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/tds_queue.sv
module tds_queue #(
   parameter int DEPTH = 8,
   parameter int TID_W = 6,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [TID_W-1:0] push_tid,
   input  logic             push_rdy,
   input  logic             pop,
   input  logic             ret_valid,
   input  logic [TID_W-1:0] ret_tid,
   output logic [TID_W-1:0] head_tid,
   output logic             head_rdy,
   output logic [CW-1:0]    cnt
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("tds_queue: DEPTH must be a power of two, at least 2");
   end

   logic [DEPTH-1:0] occ;
   logic [DEPTH-1:0] rdy;
   logic [TID_W-1:0] tids [DEPTH];
   logic [AW-1:0]    rd_p, wr_p;

   assign head_tid = tids[rd_p];
   assign head_rdy = occ[rd_p] & rdy[rd_p];

   always_ff @(posedge clk) begin
      if (rst) begin
         occ  <= '0;
         rdy  <= '0;
         rd_p <= '0;
         wr_p <= '0;
         cnt  <= '0;
         for (int i = 0; i < DEPTH; i++) tids[i] <= '0;
      end else begin
         // data return wakes a waiting entry with the same ID
         for (int i = 0; i < DEPTH; i++)
            if (ret_valid && occ[i] && !rdy[i] && tids[i] == ret_tid) rdy[i] <= 1'b1;
         if (pop) begin
            occ[rd_p] <= 1'b0;
            rd_p      <= rd_p + AW'(1);
         end
         if (push) begin
            occ[wr_p]  <= 1'b1;
            rdy[wr_p]  <= push_rdy;
            tids[wr_p] <= push_tid;
            wr_p       <= wr_p + AW'(1);
         end
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      push |-> (int'(cnt) < DEPTH));
   // R6
   pop_ready_chk: assert property (@(posedge clk) disable iff (rst)
      pop |-> head_rdy);
endmodule

// File: rtl/thread_dispatch_sched.sv
module thread_dispatch_sched import tds_pkg::*; #(
   parameter int NUM_CL = 4,
   parameter int QDEPTH = 8,
   parameter int TID_W  = 6,
   localparam int CLW = (NUM_CL > 1) ? $clog2(NUM_CL) : 1,
   localparam int NQ  = NUM_QUEUES,
   localparam int QCW = $clog2(QDEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NQ-1:0]            in_valid,
   input  logic [NQ*TID_W-1:0]      in_tid,
   output logic [NQ-1:0]            in_ready,
   output logic [NUM_CL-1:0]        iss_valid,
   output logic [NUM_CL*TID_W-1:0]  iss_tid,
   output logic [NUM_CL*TYPE_W-1:0] iss_type,
   input  logic [NUM_CL-1:0]        done_valid,
   input  logic                     susp_valid,
   input  logic [CLW-1:0]           susp_cl,
   input  logic                     ret_valid,
   input  logic [TID_W-1:0]         ret_tid,
   input  logic [NUM_CL-1:0]        fetch_req,
   output logic [NUM_CL-1:0]        fetch_gnt
);
   if (NUM_CL < 2 || (1 << CLW) != NUM_CL) begin : g_bad_cl
      $error("thread_dispatch_sched: NUM_CL must be a power of two, at least 2");
   end

   logic [NUM_CL-1:0] busy;
   logic [TID_W-1:0]  run_tid  [NUM_CL];
   logic [TYPE_W-1:0] run_type [NUM_CL];

   logic [NQ-1:0]    q_rdy, q_push, q_pop, q_prdy;
   logic [TID_W-1:0] q_htid [NQ];
   logic [TID_W-1:0] q_ptid [NQ];
   logic [QCW-1:0]   q_cnt  [NQ];

   logic [NUM_CL-1:0] cl_gnt;
   logic [NQ-1:0]     qa_gnt [NUM_CL];
   logic              do_issue;
   int                cl_idx, sel_q;
   logic              susp_ok;
   logic [TYPE_W-1:0] susp_q;

   // cluster choice: interleaved over free clusters
   tds_rr_arb #(.N(NUM_CL)) u_cl_arb (
      .clk(clk), .rst(rst),
      .req(~busy & {NUM_CL{|q_rdy}}), .adv(1'b1), .gnt(cl_gnt));

   // one queue arbiter per cluster; only the chosen cluster's one advances
   for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
      tds_rr_arb #(.N(NQ)) u_q_arb (
         .clk(clk), .rst(rst),
         .req(q_rdy), .adv(cl_gnt[c]), .gnt(qa_gnt[c]));
      assign iss_tid[c*TID_W +: TID_W]    = run_tid[c];
      assign iss_type[c*TYPE_W +: TYPE_W] = run_type[c];
   end

   // fetch grant path runs on its own
   tds_rr_arb #(.N(NUM_CL)) u_fetch_arb (
      .clk(clk), .rst(rst), .req(fetch_req), .adv(1'b1), .gnt(fetch_gnt));

   always_comb begin
      do_issue = |cl_gnt;
      cl_idx   = oh2idx(32'(cl_gnt));
      sel_q    = oh2idx(32'(qa_gnt[cl_idx]));
      q_pop    = {NQ{do_issue}} & qa_gnt[cl_idx];
      // a retire on the same cluster wins over the suspend
      susp_ok  = susp_valid && busy[susp_cl] && !done_valid[susp_cl];
      susp_q   = run_type[susp_cl];
      for (int q = 0; q < NQ; q++) begin
         int inflt;
         logic req_slot;
         inflt = 0;
         for (int c = 0; c < NUM_CL; c++)
            if (busy[c] && run_type[c] == TYPE_W'(q)) inflt++;
         req_slot    = susp_ok && susp_q == TYPE_W'(q);
         in_ready[q] = !req_slot && (int'(q_cnt[q]) + inflt < QDEPTH);
         q_push[q]   = req_slot || (in_valid[q] && in_ready[q]);
         q_prdy[q]   = !req_slot;
         q_ptid[q]   = req_slot ? run_tid[susp_cl] : in_tid[q*TID_W +: TID_W];
      end
   end

   for (genvar q = 0; q < NQ; q++) begin : g_q
      tds_queue #(.DEPTH(QDEPTH), .TID_W(TID_W)) u_queue (
         .clk(clk), .rst(rst),
         .push(q_push[q]), .push_tid(q_ptid[q]), .push_rdy(q_prdy[q]),
         .pop(q_pop[q]), .ret_valid(ret_valid), .ret_tid(ret_tid),
         .head_tid(q_htid[q]), .head_rdy(q_rdy[q]), .cnt(q_cnt[q]));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy      <= '0;
         iss_valid <= '0;
         for (int c = 0; c < NUM_CL; c++) begin
            run_tid[c]  <= '0;
            run_type[c] <= TT_VERT;
         end
      end else begin
         iss_valid <= '0;
         for (int c = 0; c < NUM_CL; c++) begin
            if (done_valid[c] || (susp_ok && int'(susp_cl) == c)) busy[c] <= 1'b0;
            if (do_issue && cl_idx == c) begin
               busy[c]      <= 1'b1;
               iss_valid[c] <= 1'b1;
               run_tid[c]   <= q_htid[sel_q];
               run_type[c]  <= TYPE_W'(sel_q);
            end
         end
      end
   end

   // R3
   single_issue_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(iss_valid));
   // R5
   susp_free_chk: assert property (@(posedge clk) disable iff (rst)
      (susp_valid && busy[susp_cl] && !done_valid[susp_cl]) |=> !busy[$past(susp_cl)]);
   for (genvar c = 0; c < NUM_CL; c++) begin : g_chk
      // R3
      issue_free_chk: assert property (@(posedge clk) disable iff (rst)
         iss_valid[c] |-> $past(!busy[c]));
   end
endmodule

// File: tb/thread_dispatch_sched_tb.sv
module thread_dispatch_sched_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCL = 4;
   localparam int TW  = 6;
   localparam int WD_CYCLES = 5000;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [2:0]     in_valid = '0;
   logic [17:0]    in_tid = '0;
   logic [2:0]     in_ready;
   logic [3:0]     iss_valid;
   logic [23:0]    iss_tid;
   logic [7:0]     iss_type;
   logic [3:0]     done_valid = '0;
   logic           susp_valid = 1'b0;
   logic [1:0]     susp_cl = '0;
   logic           ret_valid = 1'b0;
   logic [5:0]     ret_tid = '0;
   logic [3:0]     fetch_req = '0;
   logic [3:0]     fetch_gnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   thread_dispatch_sched dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_tid(in_tid), .in_ready(in_ready),
      .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_type(iss_type),
      .done_valid(done_valid), .susp_valid(susp_valid), .susp_cl(susp_cl),
      .ret_valid(ret_valid), .ret_tid(ret_tid),
      .fetch_req(fetch_req), .fetch_gnt(fetch_gnt));

   // fetch vectors: {req, expected grant}, pointer starts at requester 0
   localparam logic [7:0] FETCH_VEC [8] = '{
      {4'b1111, 4'b0001}, {4'b1111, 4'b0010}, {4'b0001, 4'b0001}, {4'b1000, 4'b1000},
      {4'b0000, 4'b0000}, {4'b0110, 4'b0010}, {4'b0110, 4'b0100}, {4'b0011, 4'b0001}};

   int checks = 0;
   int fails  = 0;
   int iss_cnt [64];
   int ret_cnt [64];
   int exp_iss [64];
   logic [NCL-1:0] occ = '0;
   int occ_tid [NCL];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // advance to the next falling edge, clear pulses, record dispatches
   task automatic tick();
      @(negedge clk);
      in_valid = '0; done_valid = '0; susp_valid = 1'b0; ret_valid = 1'b0;
      for (int c = 0; c < NCL; c++)
         if (iss_valid[c]) begin
            iss_cnt[iss_tid[c*TW +: TW]]++;
            occ[c] = 1'b1;
            occ_tid[c] = int'(iss_tid[c*TW +: TW]);
         end
   endtask

   task automatic retire(input logic [NCL-1:0] mask);
      done_valid = mask;
      for (int c = 0; c < NCL; c++)
         if (mask[c] && occ[c]) begin
            ret_cnt[occ_tid[c]]++;
            occ[c] = 1'b0;
         end
   endtask

   task automatic expect_iss(input string req, input int cl, input int tid, input int typ);
      chk(iss_valid == 4'(1 << cl), req, "iss_valid", int'(iss_valid), 1 << cl);
      chk(int'(iss_tid[cl*TW +: TW]) == tid, req, "iss_tid", int'(iss_tid[cl*TW +: TW]), tid);
      chk(int'(iss_type[cl*2 +: 2]) == typ, req, "iss_type", int'(iss_type[cl*2 +: 2]), typ);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin iss_cnt[i] = 0; ret_cnt[i] = 0; exp_iss[i] = 0; end
      repeat (3) tick();
      rst = 1'b0;
      tick();
      // R11 reset state
      chk(iss_valid == '0, "R11", "iss_valid", int'(iss_valid), 0);
      chk(in_ready == 3'b111, "R11", "in_ready", int'(in_ready), 7);
      chk(fetch_gnt == '0, "R11", "fetch_gnt", int'(fetch_gnt), 0);

      // R9 fetch arbiter vectors
      foreach (FETCH_VEC[i]) begin
         fetch_req = FETCH_VEC[i][7:4];
         #1;
         chk(fetch_gnt == FETCH_VEC[i][3:0], "R9", "fetch_gnt",
             int'(fetch_gnt), int'(FETCH_VEC[i][3:0]));
         tick();
      end
      fetch_req = '0;

      // R3 interleaving: one thread per lane together
      in_valid = 3'b111; in_tid = {6'd3, 6'd2, 6'd1};
      exp_iss[1] = 2; exp_iss[2] = 1; exp_iss[3] = 1;
      tick();
      tick(); expect_iss("R3", 0, 1, 0);
      tick(); expect_iss("R3", 1, 2, 1);
      tick(); expect_iss("R3", 2, 3, 2);

      // R5/R7 suspension of cluster 0 collides with a vertex arrival
      susp_valid = 1'b1; susp_cl = 2'd0; occ[0] = 1'b0;
      in_valid = 3'b001; in_tid = {6'd0, 6'd0, 6'd10};
      #1;
      chk(in_ready == 3'b110, "R7", "in_ready during requeue", int'(in_ready), 6);
      tick();
      ret_valid = 1'b1; ret_tid = 6'd50;   // R8 unknown ID
      tick();
      chk(iss_valid == '0, "R6", "waiting head not issued", int'(iss_valid), 0);
      in_valid = 3'b010; in_tid = {6'd0, 6'd20, 6'd0}; exp_iss[20] = 1;
      tick();
      chk(iss_valid == '0, "R8", "unknown return ignored", int'(iss_valid), 0);
      tick(); expect_iss("R6", 3, 20, 1);   // waiting vertex head skipped
      ret_valid = 1'b1; ret_tid = 6'd1;
      tick();
      chk(iss_valid == '0, "R6", "no issue before wake", int'(iss_valid), 0);
      tick(); expect_iss("R6", 0, 1, 0);

      // R1 vertex lane fills: 7 entries plus one running vertex thread
      for (int k = 0; k < 7; k++) begin
         in_valid = 3'b001; in_tid = {12'd0, 6'(30 + k)};
         #1;
         chk(in_ready[0] == 1'b1, "R1", "in_ready below limit", int'(in_ready[0]), 1);
         exp_iss[30 + k] = 1;
         tick();
      end
      in_valid = 3'b001; in_tid = {12'd0, 6'd37};
      #1;
      chk(in_ready[0] == 1'b0, "R1", "in_ready at limit", int'(in_ready[0]), 0);
      in_valid = '0;
      retire(4'b0001);
      tick();
      chk(in_ready[0] == 1'b1, "R4", "reservation released", int'(in_ready[0]), 1);
      chk(iss_valid == '0, "R4", "no issue yet", int'(iss_valid), 0);
      tick(); expect_iss("R4", 0, 30, 0);

      // R2 per-cluster queue rotation
      in_valid = 3'b110; in_tid = {6'd41, 6'd40, 6'd0};
      exp_iss[40] = 1; exp_iss[41] = 1;
      tick();
      retire(4'b1111);
      tick();
      chk(iss_valid == '0, "R2", "no issue yet", int'(iss_valid), 0);
      tick(); expect_iss("R2", 1, 41, 2);
      tick(); expect_iss("R2", 2, 31, 0);
      tick(); expect_iss("R2", 3, 32, 0);
      tick(); expect_iss("R2", 0, 40, 1);

      // drain, then R10 scoreboard
      for (int n = 0; n < 30; n++) begin
         retire(occ);
         tick();
      end
      for (int t = 0; t < 64; t++) begin
         chk(iss_cnt[t] == exp_iss[t], "R10", $sformatf("dispatch count tid %0d", t),
             iss_cnt[t], exp_iss[t]);
         chk(ret_cnt[t] == ((exp_iss[t] > 0) ? 1 : 0), "R10",
             $sformatf("retire count tid %0d", t), ret_cnt[t], (exp_iss[t] > 0) ? 1 : 0);
      end
      summary();
      $finish;
   end
endmodule